// File: doc/BRIEF.md
# Sign-LMS DTC Gain Estimator

This block sits in the feedback path of a fractional-N digital PLL that uses a single-bit phase detector and a digital-to-time converter (DTC). Once per reference cycle it receives the signed quantization error left by the divider-modulus dithering, together with the lead/lag decision of the phase detector. It learns one scale factor that maps that error onto the delay span the DTC must cover. Because the DTC is built with more delay range than the loop needs, the learnt factor is an unsigned fraction below one.

Adaptation is a sign-LMS correlation and runs in the background at all times while the loop operates. The detector sign, taken as plus one when the reference leads and minus one when it lags, multiplies the current error. That term is scaled by a power-of-two step and added into a saturating accumulator. The upper bits of the accumulator form the gain. The same strobe multiplies the error by the gain held before the update and registers the signed product. A first-order noise-shaping requantizer turns the product into a 10-bit DTC code, so that the code's average reaches finer steps than one DTC step.

Top module: `dtc_gain_lms`

## Requirements
- R1: A synchronous reset loads the accumulator with `init_gain_i` in its upper 12 bits and zeros below, so `gain_o` equals `init_gain_i`. It clears `scaled_o`, `dtc_code_o` and the requantizer residue to zero. Reset takes priority over a strobe in the same cycle.
- R2: On a clock edge with `stb_i` and `en_i` both high, the accumulator (24 bits, unsigned) adds a step. The step is the error, negated when `lead_i` is 0 (lead_i = 1 means the reference leads and counts as +1). It is multiplied by 2^12 and then shifted right arithmetically by `mu_i`, rounding toward minus infinity. `gain_o` is accumulator bits [23:12].
- R3: The accumulator saturates instead of wrapping. A sum below zero gives 0, and a sum above 2^24-1 gives 2^24-1.
- R4: When `stb_i` is low or `en_i` is low, the accumulator and `gain_o` keep their values.
- R5: On every strobe edge, `scaled_o` takes `qerr_i * gain_o`. This uses the gain held before that edge's update and is a signed 24-bit value carrying 12 fractional bits. Between strobes `scaled_o` holds. Output latency is one clock edge.
- R6: On every strobe edge, the product is offset by +2^23 to become unsigned. Its upper 10 bits form the base code and its lower 14 bits are added to a 14-bit residue. The carry out of the residue adds one to the base code, and the residue keeps the low 14 bits of the sum. `dtc_code_o` is registered on the same edge and holds between strobes.
- R7: When the base code is 1023 and the residue produces a carry, `dtc_code_o` stays at 1023 and does not wrap. The residue still updates.
- R8: With `en_i` low, strobes still update `scaled_o` and `dtc_code_o` using the frozen gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stb_i | input | 1 | One-cycle strobe per reference cycle |
| en_i | input | 1 | Adaptation enable |
| lead_i | input | 1 | Detector decision: 1 = reference leads (+1), 0 = lags (-1) |
| qerr_i | input | 12 | Signed quantization error |
| mu_i | input | 5 | Step-size right shift |
| init_gain_i | input | 12 | Gain loaded by reset |
| gain_o | output | 12 | Estimated gain, unsigned fraction of 2^12 |
| scaled_o | output | 24 | Signed scaled word, error times gain |
| dtc_code_o | output | 10 | Requantized DTC control code |

## Verification
The gain update and the product capture happen on the same strobe edge. The product must see the gain from before the update, not after it. Back-to-back strobes with large steps and alternating detector signs make the gain move on every edge, so an off-by-one-edge use of the gain shows up at once in `scaled_o`. A bench model steps the gain only after it has formed the product, and it judges both outputs at the following falling edge. The code clamp and the residue carry can also fall on the same edge. Repeated strobes at full gain and maximum error force this case, and the bench checks that the code stays at 1023 while the residue keeps advancing.

// File: rtl/dtc_gain_pkg.sv
package dtc_gain_pkg;
  // detector decision as seen by the estimator
  typedef enum logic {PD_LAG = 1'b0, PD_LEAD = 1'b1} pd_sign_e;

  localparam int unsigned QERR_W_DEF = 12;  // quantization error width (signed)
  localparam int unsigned GAIN_W_DEF = 12;  // gain width (unsigned fraction)
  localparam int unsigned ACC_W_DEF  = 24;  // accumulator width
  localparam int unsigned MU_W_DEF   = 5;   // step shift width
  localparam int unsigned CODE_W_DEF = 10;  // DTC code width
endpackage

// File: rtl/lms_gain_acc.sv
module lms_gain_acc
  import dtc_gain_pkg::*;
#(
  parameter int unsigned QW = QERR_W_DEF,
  parameter int unsigned GW = GAIN_W_DEF,
  parameter int unsigned AW = ACC_W_DEF,
  parameter int unsigned MW = MU_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stb,
  input  logic                 en,
  input  logic                 lead,
  input  logic signed [QW-1:0] qerr,
  input  logic [MW-1:0]        mu,
  input  logic [GW-1:0]        init_gain,
  output logic [GW-1:0]        gain
);
  localparam int unsigned SW = AW + 2;  // signed sum width, one guard bit each side
  localparam int unsigned LS = AW - QW; // alignment of error onto accumulator

  // sign-correlated, step-scaled increment
  function automatic logic signed [SW-1:0] f_step(
    input logic signed [QW-1:0] q, input logic ld, input logic [MW-1:0] m);
    logic signed [SW-1:0] t;
    t = {{(SW-QW){q[QW-1]}}, q};
    if (pd_sign_e'(ld) == PD_LAG) t = -t;
    t = t <<< LS;
    return t >>> m;
  endfunction

  // clamp a guarded sum into the accumulator range
  function automatic logic [AW-1:0] f_clamp(input logic signed [SW-1:0] s);
    if (s[SW-1])  return '0;
    if (s[AW])    return '1;
    return s[AW-1:0];
  endfunction

  logic [AW-1:0]        acc_q;
  logic signed [SW-1:0] step_w;
  logic signed [SW-1:0] sum_w;
  logic                 adapt_w;
  logic                 sat_lo_w;   // event: sum fell below zero
  logic                 sat_hi_w;   // event: sum passed full scale

  assign adapt_w  = stb && en;
  assign step_w   = f_step(qerr, lead, mu);
  assign sum_w    = $signed({2'b00, acc_q}) + step_w;
  assign sat_lo_w = adapt_w && sum_w[SW-1];
  assign sat_hi_w = adapt_w && !sum_w[SW-1] && sum_w[AW];

  always_ff @(posedge clk) begin
    if (rst)          acc_q <= {init_gain, {(AW-GW){1'b0}}};
    else if (adapt_w) acc_q <= f_clamp(sum_w);
  end

  assign gain = acc_q[AW-1 -: GW];

  // R4: frozen when not adapting
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !adapt_w |=> $stable(acc_q));
  // R3: floor saturation
  a_r3_floor_zero: assert property (@(posedge clk) disable iff (rst)
    sat_lo_w |=> (acc_q == '0));
  // R3: ceiling saturation
  a_r3_ceiling_full: assert property (@(posedge clk) disable iff (rst)
    sat_hi_w |=> (acc_q == '1));
  // R2: a positive step without saturation raises the accumulator
  a_r2_rises_on_pos: assert property (@(posedge clk) disable iff (rst)
    (adapt_w && !step_w[SW-1] && (step_w != '0) && !sat_hi_w) |=> (acc_q > $past(acc_q)));
  // R2: a negative step without saturation lowers the accumulator
  a_r2_falls_on_neg: assert property (@(posedge clk) disable iff (rst)
    (adapt_w && step_w[SW-1] && !sat_lo_w) |=> (acc_q < $past(acc_q)));
endmodule

// File: rtl/gain_scaler.sv
module gain_scaler
  import dtc_gain_pkg::*;
#(
  parameter int unsigned QW = QERR_W_DEF,
  parameter int unsigned GW = GAIN_W_DEF,
  localparam int unsigned PW = QW + GW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stb,
  input  logic signed [QW-1:0] qerr,
  input  logic [GW-1:0]        gain,
  output logic signed [PW-1:0] prod_c,   // combinational product, for the requantizer
  output logic signed [PW-1:0] prod_q    // registered scaled word
);
  // signed error times unsigned fraction; PW bits cannot overflow
  function automatic logic signed [PW-1:0] f_mul(
    input logic signed [QW-1:0] q, input logic [GW-1:0] g);
    logic signed [PW-1:0] a;
    logic signed [PW-1:0] b;
    a = {{GW{q[QW-1]}}, q};
    b = {{QW{1'b0}}, g};
    return a * b;
  endfunction

  assign prod_c = f_mul(qerr, gain);

  always_ff @(posedge clk) begin
    if (rst)      prod_q <= '0;
    else if (stb) prod_q <= prod_c;
  end

  // R5: holds between strobes
  a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(prod_q));
  // R5: a negative error never yields a positive scaled word
  a_r5_sign_follows: assert property (@(posedge clk) disable iff (rst)
    (stb && qerr[QW-1]) |=> (prod_q[PW-1] || (prod_q == '0)));
endmodule

// File: rtl/dtc_requant.sv
module dtc_requant
  import dtc_gain_pkg::*;
#(
  parameter int unsigned PW = QERR_W_DEF + GAIN_W_DEF,
  parameter int unsigned DW = CODE_W_DEF,
  localparam int unsigned FW = PW - DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stb,
  input  logic signed [PW-1:0] prod,
  output logic [DW-1:0]        code
);
  logic [PW-1:0] ofs_w;     // offset-binary form, +2^(PW-1)
  logic [DW-1:0] base_w;
  logic [FW-1:0] frac_w;
  logic [FW:0]   rsum_w;
  logic [DW:0]   csum_w;
  logic [FW-1:0] res_q;
  logic          clip_w;    // event: carry on a full-scale base code

  // flipping the sign bit adds half scale to a two's-complement value
  function automatic logic [PW-1:0] f_offset(input logic signed [PW-1:0] p);
    return {~p[PW-1], p[PW-2:0]};
  endfunction

  assign ofs_w  = f_offset(prod);
  assign base_w = ofs_w[PW-1 -: DW];
  assign frac_w = ofs_w[FW-1:0];
  assign rsum_w = {1'b0, res_q} + {1'b0, frac_w};
  assign csum_w = {1'b0, base_w} + {{DW{1'b0}}, rsum_w[FW]};
  assign clip_w = stb && csum_w[DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      code  <= '0;
    end else if (stb) begin
      res_q <= rsum_w[FW-1:0];
      code  <= csum_w[DW] ? {DW{1'b1}} : csum_w[DW-1:0];
    end
  end

  // R6: code and residue hold between strobes
  a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
    !stb |=> ($stable(code) && $stable(res_q)));
  // R7: clamp at full scale
  a_r7_clip_full: assert property (@(posedge clk) disable iff (rst)
    clip_w |=> (code == '1));
  // R6: the code never drops below the base it was formed from
  a_r6_not_below_base: assert property (@(posedge clk) disable iff (rst)
    stb |=> (code >= $past(base_w)));
endmodule

// File: rtl/dtc_gain_lms.sv
module dtc_gain_lms
  import dtc_gain_pkg::*;
#(
  parameter int unsigned QW = QERR_W_DEF,
  parameter int unsigned GW = GAIN_W_DEF,
  parameter int unsigned AW = ACC_W_DEF,
  parameter int unsigned MW = MU_W_DEF,
  parameter int unsigned DW = CODE_W_DEF,
  localparam int unsigned PW = QW + GW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stb_i,
  input  logic                 en_i,
  input  logic                 lead_i,
  input  logic signed [QW-1:0] qerr_i,
  input  logic [MW-1:0]        mu_i,
  input  logic [GW-1:0]        init_gain_i,
  output logic [GW-1:0]        gain_o,
  output logic signed [PW-1:0] scaled_o,
  output logic [DW-1:0]        dtc_code_o
);
  logic signed [PW-1:0] prod_c_w;

  lms_gain_acc #(.QW(QW), .GW(GW), .AW(AW), .MW(MW)) u_acc (
    .clk(clk), .rst(rst), .stb(stb_i), .en(en_i), .lead(lead_i),
    .qerr(qerr_i), .mu(mu_i), .init_gain(init_gain_i), .gain(gain_o)
  );

  gain_scaler #(.QW(QW), .GW(GW)) u_scale (
    .clk(clk), .rst(rst), .stb(stb_i), .qerr(qerr_i), .gain(gain_o),
    .prod_c(prod_c_w), .prod_q(scaled_o)
  );

  dtc_requant #(.PW(PW), .DW(DW)) u_rq (
    .clk(clk), .rst(rst), .stb(stb_i), .prod(prod_c_w), .code(dtc_code_o)
  );

  // R1: outputs cleared one edge after reset
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> ((scaled_o == '0) && (dtc_code_o == '0) && (gain_o == $past(init_gain_i))));
  // R8: with adaptation off the gain is frozen across a strobe
  a_r8_frozen_gain: assert property (@(posedge clk) disable iff (rst)
    (stb_i && !en_i) |=> (gain_o == $past(gain_o)));
endmodule

// File: tb/dtc_gain_lms_bench.sv
module dtc_gain_lms_bench;
  localparam int QW = 12, GW = 12, AW = 24, MW = 5, DW = 10;
  localparam int PW = QW + GW, FW = PW - DW;

  typedef struct packed {
    logic       s;
    logic       e;
    logic       ld;
    logic [4:0] mu;
    logic [11:0] q;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 1'b1, 1'b1, 5'd4,  12'd1000},
    '{1'b1, 1'b1, 1'b0, 5'd4,  12'd1000},
    '{1'b1, 1'b1, 1'b1, 5'd2,  -12'sd700},
    '{1'b1, 1'b0, 1'b1, 5'd0,  12'd1500},
    '{1'b0, 1'b1, 1'b1, 5'd0,  12'd2000},
    '{1'b1, 1'b1, 1'b0, 5'd0,  -12'sd2048},
    '{1'b1, 1'b1, 1'b1, 5'd31, -12'sd3},
    '{1'b1, 1'b1, 1'b1, 5'd1,  12'd1},
    '{1'b1, 1'b1, 1'b0, 5'd3,  12'd2047},
    '{1'b1, 1'b1, 1'b1, 5'd0,  12'd0},
    '{1'b1, 1'b1, 1'b1, 5'd6,  -12'sd1234},
    '{1'b1, 1'b1, 1'b0, 5'd5,  -12'sd999}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0, en = 1'b0, lead = 1'b0;
  logic signed [QW-1:0] qerr = '0;
  logic [MW-1:0] mu = '0;
  logic [GW-1:0] init_gain = 12'd2048;
  logic [GW-1:0] gain_o;
  logic signed [PW-1:0] scaled_o;
  logic [DW-1:0] dtc_code_o;

  dtc_gain_lms u_dtc_gain_lms (
    .clk(clk), .rst(rst), .stb_i(stb), .en_i(en), .lead_i(lead), .qerr_i(qerr),
    .mu_i(mu), .init_gain_i(init_gain), .gain_o(gain_o), .scaled_o(scaled_o),
    .dtc_code_o(dtc_code_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // independent model state
  longint m_acc, m_res, m_scaled, m_code;
  bit m_sat, m_clip;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset(input int g);
    m_acc = longint'(g) * (64'sd1 << (AW - GW));
    m_res = 0; m_scaled = 0; m_code = 0; m_sat = 0; m_clip = 0;
  endtask

  task automatic model_strobe(input bit e, input bit ld, input int q, input int m);
    longint g, u, hi, lo, s, t, d, top;
    g = m_acc / (64'sd1 << (AW - GW));
    m_scaled = longint'(q) * g;
    u = m_scaled + (64'sd1 << (PW - 1));
    hi = u / (64'sd1 << FW);
    lo = u % (64'sd1 << FW);
    s = m_res + lo;
    m_res = s % (64'sd1 << FW);
    m_code = hi + s / (64'sd1 << FW);
    m_clip = (m_code > 1023);
    if (m_clip) m_code = 1023;
    m_sat = 0;
    if (e) begin
      t = (ld ? longint'(q) : -longint'(q)) * (64'sd1 << (AW - QW));
      d = 64'sd1 << m;
      if (t >= 0) t = t / d;
      else t = -((-t + d - 1) / d);
      m_acc = m_acc + t;
      top = (64'sd1 << AW) - 1;
      if (m_acc < 0) begin m_acc = 0; m_sat = 1; end
      if (m_acc > top) begin m_acc = top; m_sat = 1; end
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic apply(input bit s, input bit e, input bit ld, input int q, input int m);
    string tg;
    stb = s; en = e; lead = ld; qerr = QW'(q); mu = MW'(m);
    if (s) model_strobe(e, ld, q, m);
    @(negedge clk);
    stb = 1'b0;
    tg = !(s && e) ? "R4" : (m_sat ? "R3" : "R2");
    chk(tg, "gain", longint'(gain_o), m_acc / (64'sd1 << (AW - GW)));
    chk((s && !e) ? "R8" : "R5", "scaled", longint'(scaled_o), m_scaled);
    chk(m_clip ? "R7" : "R6", "dtc_code", longint'(dtc_code_o), m_code);
  endtask

  task automatic do_reset(input int g, input bit with_stb);
    init_gain = GW'(g);
    rst = 1'b1; stb = with_stb; en = 1'b1; lead = 1'b1; qerr = 12'sd900; mu = '0;
    @(negedge clk);
    rst = 1'b0; stb = 1'b0;
    model_reset(g);
    chk("R1", "gain", longint'(gain_o), longint'(g));
    chk("R1", "scaled", longint'(scaled_o), 0);
    chk("R1", "dtc_code", longint'(dtc_code_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1..: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    do_reset(2048, 1'b0);
    // vector table: back-to-back strobes, gain moving each edge
    for (int i = 0; i < NV; i++)
      apply(VEC[i].s, VEC[i].e, VEC[i].ld, int'($signed(VEC[i].q)), int'(VEC[i].mu));

    // R1: reset wins over a simultaneous strobe, new initial gain loads
    do_reset(1000, 1'b1);
    apply(1'b1, 1'b1, 1'b0, 321, 2);

    // R3 ceiling, then R7 clamp on repeated full-scale products
    do_reset(4095, 1'b0);
    apply(1'b1, 1'b1, 1'b1, 2047, 0);
    for (int k = 0; k < 5; k++) apply(1'b1, 1'b1, 1'b1, 2047, 0);

    // R3 floor, then recovery upward with a lag decision and negative error
    do_reset(5, 1'b0);
    apply(1'b1, 1'b1, 1'b0, 2000, 0);
    apply(1'b1, 1'b1, 1'b0, -2000, 3);

    // R8 frozen adaptation with a run of strobes, R4 idle cycles between
    for (int k = 0; k < 4; k++) begin
      apply(1'b1, 1'b0, k[0], 300 * k - 700, 0);
      apply(1'b0, 1'b1, 1'b1, 1800, 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule